// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt request lines and presents a single interrupt output to a processor. Software configures it through a small byte-wide register window: a command port, a data port, a trigger-select port and a read-only cascade port. A three-word setup sequence, started by a command byte, loads the vector base, the cascade map and the end-of-interrupt mode. Until that sequence completes the interrupt output stays low.

Line 0 has the highest priority. A pending, unmasked request drives the interrupt output only when it outranks every level already in service. When the processor pulses acknowledge, the controller latches the winning level into the in-service register (unless automatic end-of-interrupt is on) and returns the vector base plus the level one cycle later. If no request qualifies at acknowledge, it returns the vector for level 7 and touches no in-service bit. Each line can be edge or level sensitive.

Top module: `pic_ctl`

## Requirements
- R1: After reset the interrupt output is low, the mask reads 0xFF at address 1, address 0 reads the request register (0x00), the trigger register reads 0x00 at address 2 and the controller is uninitialized.
- R2: A command byte 0x11 at address 0 starts setup; the next three data-port (address 1) writes load the vector base, the cascade map and the mode word, in that order. The interrupt output stays low until the third word is written.
- R3: At acknowledge, the winning level n is reported as vector base+n (8-bit sum) with vec_valid high in the cycle after the acknowledge pulse.
- R4: Outside the setup sequence a data-port write loads the mask, bit n = 1 masking line n; the mask reads back at address 1, and a mask of 0xFF keeps the interrupt output low.
- R5: Command 0x0B selects the in-service register for address-0 reads and 0x0A selects the request register; the choice holds until changed.
- R6: Priority is fixed with line 0 highest; a request is eligible only when unmasked and of strictly higher priority than every in-service level.
- R7: Command 0x60+n (n = 0..7) clears in-service bit n only.
- R8: When bit 1 of the mode word is 1 (automatic end-of-interrupt), acknowledge leaves the in-service register unchanged.
- R9: When no request is eligible at acknowledge, the vector is base+7 and the in-service register is unchanged, even if line 7 is masked.
- R10: Address 2 holds the trigger register, bit n = 1 making line n level sensitive; an edge-sensitive line latches a request on a rising edge that clears when that level is acknowledged, and a level-sensitive request follows the line.
- R11: The cascade map written during setup reads back at address 3.
- R12: The interrupt output is high exactly when the controller is initialized and at least one request is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 command, 1 data, 2 trigger, 3 cascade |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | One-cycle acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector for the last acknowledge |
| vec_valid | output | 1 | Vector valid, one cycle after ack |

## Verification
A corrupted in-service register shows up as a wrong nesting decision: the interrupt output rises or stays low against the expected priority within one cycle of the bad update, and the in-service readback at address 0 exposes the exact bits. A wrong request latch or priority pick appears as a wrong vector in the cycle after acknowledge. A stuck setup state keeps the interrupt output low or turns mask writes into configuration writes, which the mask and cascade readbacks reveal at once.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_LINES = 8;
    localparam int LVL_W     = $clog2(NUM_LINES);
    localparam int BYTE_W    = 8;

    localparam logic [7:0] CMD_INIT    = 8'h11;
    localparam logic [7:0] CMD_RD_REQ  = 8'h0A;
    localparam logic [7:0] CMD_RD_SVC  = 8'h0B;
    localparam logic [4:0] CMD_EOI_TOP = 5'b01100;
    localparam int         MODE_AUTO_BIT = 1;

    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_TRIG = 2'd2;
    localparam logic [1:0] A_CASC = 2'd3;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_WBASE,
        ST_WCASC,
        ST_WMODE,
        ST_READY
    } setup_st_e;

    typedef struct packed {
        logic [BYTE_W-1:0]    base;
        logic [BYTE_W-1:0]    casc;
        logic                 auto_eoi;
        logic                 rd_svc;
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] trig;
        logic                 ready;
    } cfg_t;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    // Lowest set index wins (index 0 is the highest priority).
    function automatic pick_t pick_top(input logic [NUM_LINES-1:0] v);
        pick_t p;
        p.hit = 1'b0;
        p.lvl = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.lvl = LVL_W'(i);
            end
        end
        return p;
    endfunction

    // Lines strictly above the highest-priority in-service level.
    function automatic logic [NUM_LINES-1:0] above_svc(input logic [NUM_LINES-1:0] svc);
        logic [NUM_LINES-1:0] low;
        low = svc & (~svc + 1'b1);
        return low - 1'b1;
    endfunction
endpackage

// File: rtl/pic_regif.sv
module pic_regif
    import pic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            addr,
    input  logic [BYTE_W-1:0]     wdata,
    output cfg_t                  cfg,
    output logic                  eoi_valid,
    output logic [LVL_W-1:0]      eoi_lvl,
    output logic                  init_start
);
    setup_st_e st;
    logic      cmd_wr;
    logic      dat_wr;

    assign cmd_wr     = wr_en && (addr == A_CMD);
    assign dat_wr     = wr_en && (addr == A_DATA);
    assign init_start = cmd_wr && (wdata == CMD_INIT);
    assign eoi_valid  = cmd_wr && (wdata[7:3] == CMD_EOI_TOP);
    assign eoi_lvl    = wdata[LVL_W-1:0];
    assign cfg.ready  = (st == ST_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_UNINIT;
            cfg.base     <= '0;
            cfg.casc     <= '0;
            cfg.auto_eoi <= 1'b0;
            cfg.rd_svc   <= 1'b0;
            cfg.mask     <= '1;
            cfg.trig     <= '0;
        end else begin
            if (init_start) begin
                st <= ST_WBASE;
            end else if (cmd_wr && wdata == CMD_RD_REQ) begin
                cfg.rd_svc <= 1'b0;
            end else if (cmd_wr && wdata == CMD_RD_SVC) begin
                cfg.rd_svc <= 1'b1;
            end
            if (dat_wr) begin
                unique case (st)
                    ST_WBASE: begin
                        cfg.base <= wdata;
                        st       <= ST_WCASC;
                    end
                    ST_WCASC: begin
                        cfg.casc <= wdata;
                        st       <= ST_WMODE;
                    end
                    ST_WMODE: begin
                        cfg.auto_eoi <= wdata[MODE_AUTO_BIT];
                        st           <= ST_READY;
                    end
                    default: cfg.mask <= wdata[NUM_LINES-1:0];
                endcase
            end
            if (wr_en && addr == A_TRIG) begin
                cfg.trig <= wdata[NUM_LINES-1:0];
            end
        end
    end

    AST_SETUP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WMODE && dat_wr && !init_start) |=> cfg.ready) // R2
        else $error("setup did not complete after mode word");
endmodule

// File: rtl/pic_request.sv
module pic_request
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] trig,
    input  logic                 clr_valid,
    input  logic [LVL_W-1:0]     clr_lvl,
    output logic [NUM_LINES-1:0] irr
);
    logic [NUM_LINES-1:0] prev;
    logic [NUM_LINES-1:0] edge_req;
    logic [NUM_LINES-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        if (clr_valid) clr_vec[clr_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= '0;
            edge_req <= '0;
        end else begin
            prev     <= irq_in;
            edge_req <= (edge_req & ~clr_vec) | (irq_in & ~prev);
        end
    end

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            assign irr[g] = trig[g] ? irq_in[g] : edge_req[g];
        end
    endgenerate

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
        (irq_in[0] && !prev[0] && !trig[0]) |=> edge_req[0]) // R10
        else $error("rising edge not latched");
endmodule

// File: rtl/pic_service.sv
module pic_service
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cfg_t                 cfg,
    input  logic [NUM_LINES-1:0] irr,
    input  logic                 ack,
    input  logic                 eoi_valid,
    input  logic [LVL_W-1:0]     eoi_lvl,
    input  logic                 init_start,
    output logic [NUM_LINES-1:0] isr,
    output logic                 int_out,
    output logic [BYTE_W-1:0]    vector,
    output logic                 vec_valid,
    output logic                 clr_valid,
    output logic [LVL_W-1:0]     clr_lvl
);
    logic [NUM_LINES-1:0] eligible;
    pick_t                win;
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] eoi_vec;

    assign eligible  = cfg.ready ? (irr & ~cfg.mask & above_svc(isr)) : '0;
    assign win       = pick_top(eligible);
    assign int_out   = |eligible;
    assign clr_valid = ack && win.hit;
    assign clr_lvl   = win.lvl;

    always_comb begin
        set_vec = '0;
        eoi_vec = '0;
        if (ack && win.hit && !cfg.auto_eoi) set_vec[win.lvl] = 1'b1;
        if (eoi_valid) eoi_vec[eoi_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr       <= '0;
            vector    <= '0;
            vec_valid <= 1'b0;
        end else begin
            if (init_start) isr <= '0;
            else            isr <= (isr & ~eoi_vec) | set_vec;
            vec_valid <= ack;
            if (ack) begin
                vector <= cfg.base + (win.hit ? BYTE_W'(win.lvl) : BYTE_W'(NUM_LINES - 1));
            end
        end
    end

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && !ack) |=> !isr[$past(eoi_lvl)]) // R7
        else $error("EOI left bit set");
    AST_ISR_SET: assert property (@(posedge clk) disable iff (rst)
        (ack && win.hit && !cfg.auto_eoi && !eoi_valid && !init_start) |=> isr[$past(win.lvl)]) // R6
        else $error("in-service bit not set at acknowledge");
    AST_AUTO_EOI: assert property (@(posedge clk) disable iff (rst)
        (ack && cfg.auto_eoi && !eoi_valid && !init_start) |=> $stable(isr)) // R8
        else $error("auto EOI changed in-service register");
    AST_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (ack && !win.hit && !eoi_valid && !init_start) |=> $stable(isr)) // R9
        else $error("spurious acknowledge changed in-service register");
endmodule

// File: rtl/pic_ctl.sv
module pic_ctl
    import pic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  irq_in,
    input  logic        ack,
    output logic        int_out,
    output logic [7:0]  vector,
    output logic        vec_valid
);
    cfg_t                 cfg;
    logic                 eoi_valid;
    logic [LVL_W-1:0]     eoi_lvl;
    logic                 init_start;
    logic [NUM_LINES-1:0] irr;
    logic [NUM_LINES-1:0] isr;
    logic                 clr_valid;
    logic [LVL_W-1:0]     clr_lvl;

    pic_regif u_regif (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cfg(cfg), .eoi_valid(eoi_valid), .eoi_lvl(eoi_lvl), .init_start(init_start)
    );

    pic_request u_request (
        .clk(clk), .rst(rst), .irq_in(irq_in), .trig(cfg.trig),
        .clr_valid(clr_valid), .clr_lvl(clr_lvl), .irr(irr)
    );

    pic_service u_service (
        .clk(clk), .rst(rst), .cfg(cfg), .irr(irr), .ack(ack),
        .eoi_valid(eoi_valid), .eoi_lvl(eoi_lvl), .init_start(init_start),
        .isr(isr), .int_out(int_out), .vector(vector), .vec_valid(vec_valid),
        .clr_valid(clr_valid), .clr_lvl(clr_lvl)
    );

    always_comb begin
        unique case (addr)
            A_CMD:   rdata = cfg.rd_svc ? isr : irr;
            A_DATA:  rdata = cfg.mask;
            A_TRIG:  rdata = cfg.trig;
            default: rdata = cfg.casc;
        endcase
    end

    AST_NO_INT_UNINIT: assert property (@(posedge clk) disable iff (rst)
        !cfg.ready |-> !int_out) // R2
        else $error("interrupt before setup");
    AST_MASK_ALL: assert property (@(posedge clk) disable iff (rst)
        (cfg.mask == '1) |-> !int_out) // R4
        else $error("interrupt with all lines masked");
    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        ack |=> vec_valid) // R3
        else $error("vector not valid after acknowledge");
endmodule

// File: tb/pic_ctl_tb.sv
module pic_ctl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] irq_in = 8'h00;
    logic       ack = 1'b0;
    logic       int_out;
    logic [7:0] vector;
    logic       vec_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pic_ctl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .ack(ack), .int_out(int_out),
        .vector(vector), .vec_valid(vec_valid)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_line(input int n);
        @(negedge clk);
        irq_in[n] = 1'b1;
        @(negedge clk);
        irq_in[n] = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_ack(output logic [7:0] v, output logic vv);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        v = vector; vv = vec_valid;
    endtask

    task automatic setup(input logic [7:0] base, input logic [7:0] casc, input logic [7:0] mode);
        wr(2'd0, 8'h11);
        wr(2'd1, base);
        wr(2'd1, casc);
        wr(2'd1, mode);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        logic       vv;
        logic [7:0] base;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 int", {7'd0, int_out}, 8'h00);
        rd(2'd1, d); chk("R1 mask", d, 8'hFF);
        rd(2'd0, d); chk("R1 req", d, 8'h00);
        rd(2'd2, d); chk("R1 trig", d, 8'h00);

        // R2 no interrupt before setup, even unmasked
        wr(2'd1, 8'h00);
        pulse_line(3);
        chk("R2 uninit int", {7'd0, int_out}, 8'h00);
        rd(2'd0, d); chk("R10 edge latched", d, 8'h08);
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h20);
        wr(2'd1, 8'h04);
        chk("R2 int before mode", {7'd0, int_out}, 8'h00);
        wr(2'd1, 8'h01);
        chk("R2 int after mode", {7'd0, int_out}, 8'h01);
        rd(2'd1, d); chk("R2 mask kept", d, 8'h00);
        rd(2'd3, d); chk("R11 cascade", d, 8'h04);
        do_ack(v, vv);
        chk("R3 valid", {7'd0, vv}, 8'h01);
        chk("R3 vector", v, 8'h23);
        rd(2'd0, d); chk("R10 edge cleared", d, 8'h00);
        wr(2'd0, 8'h63);

        // Sweep every line for two bases
        for (int b = 0; b < 2; b++) begin
            base = (b == 0) ? 8'h20 : 8'hFC;
            setup(base, 8'h04, 8'h01);
            for (int n = 0; n < 8; n++) begin
                pulse_line(n);
                chk("R12 pending", {7'd0, int_out}, 8'h01);
                do_ack(v, vv);
                chk("R3 sweep vector", v, base + 8'(n));
                wr(2'd0, 8'h0B);
                rd(2'd0, d); chk("R5 svc view", d, 8'h01 << n);
                rd(2'd0, d); chk("R5 persists", d, 8'h01 << n);
                wr(2'd0, 8'h60 + 8'(n));
                rd(2'd0, d); chk("R7 eoi", d, 8'h00);
                wr(2'd0, 8'h0A);
                rd(2'd0, d); chk("R5 req view", d, 8'h00);
            end
        end

        // R6 all priority pairs
        base = 8'h40;
        setup(base, 8'h04, 8'h01);
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                @(negedge clk);
                irq_in[i] = 1'b1; irq_in[j] = 1'b1;
                @(negedge clk);
                irq_in = 8'h00;
                do_ack(v, vv);
                chk("R6 winner", v, base + 8'(i));
                chk("R6 lower blocked", {7'd0, int_out}, 8'h00);
                wr(2'd0, 8'h60 + 8'(i));
                chk("R12 after eoi", {7'd0, int_out}, 8'h01);
                do_ack(v, vv);
                chk("R6 second", v, base + 8'(j));
                wr(2'd0, 8'h60 + 8'(j));
            end
        end

        // R6/R7 nesting
        pulse_line(5);
        do_ack(v, vv);
        pulse_line(2);
        chk("R6 nest int", {7'd0, int_out}, 8'h01);
        do_ack(v, vv);
        chk("R6 nest vector", v, base + 8'd2);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); chk("R6 nest svc", d, 8'h24);
        wr(2'd0, 8'h62);
        rd(2'd0, d); chk("R7 only one", d, 8'h20);
        wr(2'd0, 8'h65);
        rd(2'd0, d); chk("R7 cleared", d, 8'h00);
        wr(2'd0, 8'h0A);

        // R4 mask
        wr(2'd1, 8'h10);
        rd(2'd1, d); chk("R4 mask read", d, 8'h10);
        pulse_line(4);
        chk("R4 masked", {7'd0, int_out}, 8'h00);
        wr(2'd1, 8'h00);
        chk("R4 unmasked", {7'd0, int_out}, 8'h01);
        do_ack(v, vv);
        chk("R4 vector", v, base + 8'd4);
        wr(2'd0, 8'h64);
        pulse_line(1);
        wr(2'd1, 8'hFF);
        chk("R4 all masked", {7'd0, int_out}, 8'h00);
        // R9 spurious with line 7 masked
        do_ack(v, vv);
        chk("R9 masked spurious", v, base + 8'd7);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); chk("R9 svc untouched", d, 8'h00);
        wr(2'd0, 8'h0A);
        wr(2'd1, 8'h00);
        do_ack(v, vv);
        wr(2'd0, 8'h61);

        // R10 level line
        wr(2'd2, 8'h40);
        rd(2'd2, d); chk("R10 trig read", d, 8'h40);
        @(negedge clk); irq_in[6] = 1'b1;
        #1 chk("R10 level int", {7'd0, int_out}, 8'h01);
        @(negedge clk); irq_in[6] = 1'b0;
        #1 chk("R10 level drop", {7'd0, int_out}, 8'h00);
        do_ack(v, vv);
        chk("R9 spurious vector", v, base + 8'd7);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); chk("R9 no svc", d, 8'h00);
        @(negedge clk); irq_in[6] = 1'b1;
        do_ack(v, vv);
        chk("R10 level vector", v, base + 8'd6);
        rd(2'd0, d); chk("R10 level svc", d, 8'h40);
        wr(2'd0, 8'h66);
        chk("R10 level reasserts", {7'd0, int_out}, 8'h01);
        @(negedge clk); irq_in[6] = 1'b0;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h0A);

        // R8 automatic EOI
        setup(8'h80, 8'h02, 8'h03);
        rd(2'd3, d); chk("R11 cascade rewrite", d, 8'h02);
        pulse_line(1);
        do_ack(v, vv);
        chk("R8 vector", v, 8'h81);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); chk("R8 svc empty", d, 8'h00);
        pulse_line(3);
        chk("R8 next int", {7'd0, int_out}, 8'h01);

        finish_run();
    end
endmodule